// File: doc/BRIEF.md
# Infrared Carrier Period and High-Time Meter

This block watches a raw infrared input that still carries its modulation. It measures the carrier in ticks of a fixed time base, normally 500 ns, which gives a 2 MHz tick. Two values are measured: the full period, from one rising edge to the next, and the high time, from a rising edge to the falling edge that follows it. Each completed measurement is published in a status word. The period byte carries a valid flag in its top bit and the 7-bit period count below it. A separate 7-bit field holds the high count. From these, downstream logic works out the frequency as 2,000,000 / period and the duty cycle as high × 100 / period.

The input first passes through a synchroniser, and then an edge detector finds its rising and falling edges. A tick divider is re-phased on every rising edge, so each interval is counted from the moment it starts. Measurement runs only while carrier detection is enabled, as it is in learning mode. A read strobe clears the valid flag. A newer measurement replaces an older one that was never read.

Top module: `ir_carrier_meter`

## Requirements
- R1: After reset the valid flag (stat_period bit 7), the period count (stat_period[6:0]) and the high count (stat_high) are all zero.
- R2: When a rising edge closes a measurement, the period count is the number of whole ticks between two consecutive rising edges of the input: floor(cycles / TICK_DIV). This count appears on stat_period[6:0], and bit 7 is set to 1.
- R3: The high count published with a period is the number of whole ticks from the opening rising edge to the next falling edge. It is never larger than the period count.
- R4: A read strobe clears the valid flag on the next clock edge. Both counts keep their values.
- R5: If a measurement is published in the same cycle as a read strobe, the new measurement wins, and the valid flag stays 1 and carries the new counts.
- R6: If the period count reaches 127 ticks before the closing rising edge, the measurement is discarded. Valid is not set, and the previous counts are kept.
- R7: If the period count is zero (two rising edges less than one tick apart), nothing is published.
- R8: While detect_en is 0, nothing is published. After detect_en returns to 1, the first rising edge only arms the meter, and the following one publishes.
- R9: A new measurement overwrites an unread earlier one.
- R10: After reset, the first rising edge only arms the meter and publishes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| detect_en | input | 1 | Carrier detection enable |
| ir_raw | input | 1 | Raw modulated infrared input, asynchronous |
| rd_stb | input | 1 | Status read strobe; clears the valid flag |
| stat_period | output | 8 | Bit 7 valid, bits 6:0 period in ticks |
| stat_high | output | 7 | High time in ticks |

## Verification
Publishing a new measurement and clearing the valid flag through a read can both happen in the same clock edge. To provoke this, the bench raises the input and then counts the two synchroniser flops and the edge-detect flop. It then places a one-cycle read strobe exactly on the edge where the rising edge publishes. The result is judged correct when the valid flag remains set with the new period and high counts. A second, isolated strobe must then clear the flag.

// File: rtl/ircm_pkg.sv
package ircm_pkg;
  localparam int unsigned CNT_W = 7;
  localparam int unsigned STAT_W = CNT_W + 1;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX = '1;
  typedef struct packed {
    cnt_t period;
    cnt_t high;
  } meas_t;
endpackage

// File: rtl/ircm_sync.sv
module ircm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb st_d = d;
    end else begin : g_many
      always_comb st_d = {st_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/ircm_tick.sv
module ircm_tick #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;

  always_comb begin
    tick = (div_q == LAST);
    if (restart)   div_d = DIV_W'(1);
    else if (tick) div_d = '0;
    else           div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/ircm_span.sv
module ircm_span
  import ircm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  tick,
  input  logic  rise,
  input  logic  fall,
  output logic  pub_vld,
  output meas_t pub_meas
);
  cnt_t cnt_q, cnt_d;
  cnt_t high_q, high_d;
  logic armed_q, armed_d;
  logic fell_q, fell_d;
  logic sat;

  always_comb begin
    sat      = (cnt_q == CNT_MAX);
    pub_vld  = en && rise && armed_q && fell_q && !sat && (cnt_q != '0);
    pub_meas = '{period: cnt_q, high: high_q};

    cnt_d   = cnt_q;
    high_d  = high_q;
    armed_d = armed_q;
    fell_d  = fell_q;
    if (!en) begin
      cnt_d   = '0;
      armed_d = 1'b0;
      fell_d  = 1'b0;
    end else if (rise) begin
      cnt_d   = '0;
      high_d  = '0;
      armed_d = 1'b1;
      fell_d  = 1'b0;
    end else begin
      if (tick && armed_q && !sat) cnt_d = cnt_t'(cnt_q + 1'b1);
      if (fall && armed_q && !sat) begin
        high_d = cnt_q;
        fell_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      high_q  <= '0;
      armed_q <= 1'b0;
      fell_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      high_q  <= high_d;
      armed_q <= armed_d;
      fell_q  <= fell_d;
    end
  end
endmodule

// File: rtl/ir_carrier_meter.sv
module ir_carrier_meter
  import ircm_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              detect_en,
  input  logic              ir_raw,
  input  logic              rd_stb,
  output logic [STAT_W-1:0] stat_period,
  output logic [CNT_W-1:0]  stat_high
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic ir_s, prev_q, rise, fall, tick, pub_vld;
  meas_t pub_meas;

  ircm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(ir_raw), .q(ir_s)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) prev_q <= 1'b0;
    else            prev_q <= ir_s;
  end

  always_comb begin
    rise = ir_s && !prev_q;
    fall = !ir_s && prev_q;
  end

  ircm_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .restart(rise), .tick(tick)
  );

  ircm_span u_span (
    .clk(clk), .rst_n(rst_int_n), .en(detect_en), .tick(tick),
    .rise(rise), .fall(fall), .pub_vld(pub_vld), .pub_meas(pub_meas)
  );

  meas_t meas_q;
  logic  meas_en;
  logic  valid_q, valid_d;

  always_comb begin
    meas_en = pub_vld;
    valid_d = valid_q;
    if (pub_vld)     valid_d = 1'b1;
    else if (rd_stb) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      meas_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (meas_en) meas_q <= pub_meas;
    end
  end

  assign stat_period = {valid_q, meas_q.period};
  assign stat_high   = meas_q.high;
endmodule

// File: rtl/ircm_checker.sv
module ircm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       detect_en,
  input logic       rd_stb,
  input logic       pub_vld,
  input logic [7:0] stat_period,
  input logic [6:0] stat_high
);
  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_period[7] |-> (stat_period[6:0] != 7'd0 && stat_period[6:0] != 7'd127));

  assert_high_le_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_period[7] |-> (stat_high <= stat_period[6:0]));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !pub_vld) |=> !stat_period[7]);

  assert_publish_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pub_vld |=> stat_period[7]);

  assert_no_pub_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !detect_en |-> !pub_vld);

  assert_hold_without_pub_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pub_vld |=> ($stable(stat_period[6:0]) && $stable(stat_high)));
endmodule

bind ir_carrier_meter ircm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .detect_en(detect_en), .rd_stb(rd_stb),
  .pub_vld(pub_vld), .stat_period(stat_period), .stat_high(stat_high)
);

// File: tb/tb_ir_carrier_meter.sv
module tb_ir_carrier_meter;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n, detect_en, ir_raw, rd_stb;
  logic [7:0] stat_period;
  logic [6:0] stat_high;
  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ir_carrier_meter #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .detect_en(detect_en), .ir_raw(ir_raw),
    .rd_stb(rd_stb), .stat_period(stat_period), .stat_high(stat_high)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    ir_raw = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int h, input int l);
    ir_raw = 1'b1;
    repeat (h) @(negedge clk);
    ir_raw = 1'b0;
    repeat (l) @(negedge clk);
  endtask

  task automatic burst(input int h, input int l, input int n);
    for (int i = 0; i < n; i++) pulse(h, l);
  endtask

  task automatic read_once();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 valid", stat_period[7], 0);
    chk("R1 period", stat_period[6:0], 0);
    chk("R1 high", stat_high, 0);
  endtask

  task automatic t_first_and_basic();
    pulse(40, 60);
    idle(10);
    chk("R10 first edge arms only", stat_period[7], 0);
    idle(600);
    burst(40, 60, 4);
    idle(10);
    chk("R2 valid", stat_period[7], 1);
    chk("R2 period 100cyc", stat_period[6:0], 25);
    chk("R3 high 40cyc", stat_high, 10);
  endtask

  task automatic t_overwrite();
    idle(600);
    burst(12, 20, 3);
    idle(10);
    chk("R9 valid", stat_period[7], 1);
    chk("R9 period overwritten", stat_period[6:0], 8);
    chk("R9 high overwritten", stat_high, 3);
  endtask

  task automatic t_read();
    read_once();
    chk("R4 valid cleared", stat_period[7], 0);
    chk("R4 period kept", stat_period[6:0], 8);
    chk("R4 high kept", stat_high, 3);
  endtask

  task automatic t_saturate();
    idle(600);
    pulse(8, 600);
    pulse(8, 10);
    chk("R6 discarded", stat_period[7], 0);
    chk("R6 period kept", stat_period[6:0], 8);
    chk("R6 high kept", stat_high, 3);
  endtask

  task automatic t_zero();
    idle(600);
    burst(1, 1, 4);
    idle(10);
    chk("R7 zero period", stat_period[7], 0);
    chk("R7 period kept", stat_period[6:0], 8);
  endtask

  task automatic t_disable();
    idle(600);
    detect_en = 1'b0;
    burst(40, 60, 4);
    idle(10);
    chk("R8 disabled", stat_period[7], 0);
    detect_en = 1'b1;
    idle(5);
    pulse(40, 60);
    chk("R8 rearm only", stat_period[7], 0);
    pulse(40, 60);
    chk("R8 after rearm valid", stat_period[7], 1);
    chk("R8 after rearm period", stat_period[6:0], 25);
    chk("R8 after rearm high", stat_high, 10);
  endtask

  task automatic t_collide();
    idle(600);
    read_once();
    pulse(8, 12);
    ir_raw = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rd_stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_stb = 1'b0;
    chk("R5 valid kept", stat_period[7], 1);
    chk("R5 period new", stat_period[6:0], 5);
    chk("R5 high new", stat_high, 2);
    read_once();
    chk("R4 later read clears", stat_period[7], 0);
    ir_raw = 1'b0;
    idle(5);
  endtask

  initial begin
    rst_n = 1'b0; detect_en = 1'b0; ir_raw = 1'b0; rd_stb = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    detect_en = 1'b1;
    @(negedge clk);
    t_first_and_basic();
    t_overwrite();
    t_read();
    t_saturate();
    t_zero();
    t_disable();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule